// File: doc/BRIEF.md
# Single-Bin 64-Point Parallel FFT Engine

This block evaluates one output bin of a 64-point discrete Fourier transform per clock. All 64 complex samples are presented at once on two wide buses, and a 6-bit bin index chooses the frequency to compute. The index is split into three base-4 digits, k = k0 + 4·k1 + 16·k2. Each digit steers one level of radix-4 butterflies, so every level forms only the partial sums that the chosen bin needs. Results therefore leave the engine in whatever order the indices are requested. There is no reorder storage between levels or at the output.

The datapath has three butterfly levels with two twiddle rotations between them. The twiddles are W64^(4·n1·k0) after the first level and W64^(n0·(k0+4·k1)) after the second. The twiddle values are fixed constants in Q1.15 format. Every butterfly level divides its sum by four with rounding, so the output is the transform divided by 64. The pipeline has four register stages and accepts a new index on every clock, as long as the sample buses are held steady while any request is in flight.

Top module: `fft64_bin_select`

## Requirements
- R1: While reset is high, and in the first clock after it is released, `out_valid` is low and the output words are zero. A request made during reset never produces an output.
- R2: A request sampled with `bin_req` high at rising edge e yields `out_valid` high in the cycle after edge e+3. A cycle with `bin_req` low yields `out_valid` low four edges later.
- R3: Requests on consecutive clocks produce results on consecutive clocks, in the order requested, each for its own index.
- R4: Sample n occupies bits [16n+15:16n] of `smp_re` and `smp_im` (two's complement). The result for index k is within ±2 LSB, in both parts, of round(Σ x[n]·e^(−j2πnk/64) / 64), for inputs within ±8191.
- R5: A constant input c on all 64 samples gives exactly c at index 0 and exactly 0 at every other index.
- R6: An impulse of real value 6400 at sample 0, with all other samples zero, gives exactly 100 + j0 at every index.
- R7: While `out_valid` is low, `bin_re` and `bin_im` keep their previous values.
- R8: Inside a butterfly, four equal inputs with a non-zero digit give an exact zero. With a zero twiddle exponent, a rotation returns its input unchanged for magnitudes below 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_re | input | 1024 | Real parts of the 64 samples, sample n at [16n+15:16n] |
| smp_im | input | 1024 | Imaginary parts of the 64 samples, same layout |
| bin_req | input | 1 | Request strobe for the index on `bin_idx` |
| bin_idx | input | 6 | Output bin index k |
| out_valid | output | 1 | High when `bin_re`/`bin_im` carry a new result |
| bin_re | output | 16 | Real part of the result (transform / 64) |
| bin_im | output | 16 | Imaginary part of the result (transform / 64) |

## Verification
The latency and hold properties assume that the sample buses do not change while any request is between the input and the output. The bench follows this rule: it loads a new sample set only after four idle clocks have emptied the pipeline. The accuracy bound holds only when inputs stay in ±8191, which keeps every partial sum clear of saturation. Random sample sets are drawn inside that range, while the constant and impulse sets use values chosen so that every rounding step is exact.

// File: rtl/fft64_pkg.sv
package fft64_pkg;

    localparam int DW    = 16;            // data word width
    localparam int TW    = 16;            // twiddle word width (Q1.15)
    localparam int FRAC  = TW - 1;        // twiddle fraction bits
    localparam int LOG_N = 6;             // log2 of transform size
    localparam int NPT   = 1 << LOG_N;    // 64 points
    localparam int RDX   = 4;             // radix
    localparam int NBF1  = NPT / RDX;     // butterflies in first level
    localparam int LAT   = 4;             // pipeline depth
    localparam int PW    = DW + TW + 1;   // product sum width

    typedef struct packed {
        logic [DW-1:0] re;
        logic [DW-1:0] im;
    } cplx_t;

    // clamp a wide signed value into DW bits
    function automatic logic [DW-1:0] clamp_dw(input logic signed [PW-1:0] v);
        logic signed [PW-1:0] hi;
        logic signed [PW-1:0] lo;
        hi = PW'((1 << (DW - 1)) - 1);
        lo = -PW'(1 << (DW - 1));
        if (v > hi)      return hi[DW-1:0];
        else if (v < lo) return lo[DW-1:0];
        else             return v[DW-1:0];
    endfunction

    // cos(2*pi*r/64) for r = 0..16, Q1.15
    function automatic logic signed [TW-1:0] qcos(input logic [4:0] r);
        case (r)
            5'd0:    return 16'sd32767;
            5'd1:    return 16'sd32610;
            5'd2:    return 16'sd32138;
            5'd3:    return 16'sd31357;
            5'd4:    return 16'sd30274;
            5'd5:    return 16'sd28899;
            5'd6:    return 16'sd27246;
            5'd7:    return 16'sd25330;
            5'd8:    return 16'sd23170;
            5'd9:    return 16'sd20788;
            5'd10:   return 16'sd18205;
            5'd11:   return 16'sd15447;
            5'd12:   return 16'sd12540;
            5'd13:   return 16'sd9512;
            5'd14:   return 16'sd6393;
            5'd15:   return 16'sd3212;
            default: return 16'sd0;
        endcase
    endfunction

    // W64^m = cos(2*pi*m/64) - j*sin(2*pi*m/64)
    function automatic cplx_t twiddle(input logic [LOG_N-1:0] m);
        logic [4:0]             r;
        logic signed [TW-1:0]   ca;
        logic signed [TW-1:0]   sa;
        logic signed [TW-1:0]   cs;
        logic signed [TW-1:0]   sn;
        cplx_t                  w;
        r  = {1'b0, m[3:0]};
        ca = qcos(r);
        sa = qcos(5'd16 - r);
        case (m[5:4])
            2'd0:    begin cs = ca;  sn = sa;  end
            2'd1:    begin cs = -sa; sn = ca;  end
            2'd2:    begin cs = -ca; sn = -sa; end
            default: begin cs = sa;  sn = -ca; end
        endcase
        w.re = cs;
        w.im = -sn;
        return w;
    endfunction

endpackage

// File: rtl/r4_pick_bfly.sv
module r4_pick_bfly
    import fft64_pkg::*;
(
    input  cplx_t      a [RDX],
    input  logic [1:0] k,
    output cplx_t      y
);
    localparam int SW = DW + 3;

    logic signed [SW-1:0] acc_re;
    logic signed [SW-1:0] acc_im;
    logic signed [SW-1:0] t_re;
    logic signed [SW-1:0] t_im;
    logic signed [PW-1:0] sh_re;
    logic signed [PW-1:0] sh_im;
    logic [1:0]           p;

    always_comb begin
        acc_re = '0;
        acc_im = '0;
        for (int i = 0; i < RDX; i++) begin
            p    = 2'(2'(i) * k);
            t_re = SW'($signed(a[i].re));
            t_im = SW'($signed(a[i].im));
            case (p)
                2'd0: begin acc_re = acc_re + t_re; acc_im = acc_im + t_im; end
                2'd1: begin acc_re = acc_re + t_im; acc_im = acc_im - t_re; end
                2'd2: begin acc_re = acc_re - t_re; acc_im = acc_im - t_im; end
                default: begin acc_re = acc_re - t_im; acc_im = acc_im + t_re; end
            endcase
        end
        sh_re = PW'((acc_re + SW'(2)) >>> 2);
        sh_im = PW'((acc_im + SW'(2)) >>> 2);
        y.re  = clamp_dw(sh_re);
        y.im  = clamp_dw(sh_im);
    end

    // R8
    always_comb begin
        cancel_sum_chk: assert (!((k != 2'd0) &&
                                  (a[0] == a[1]) && (a[1] == a[2]) && (a[2] == a[3]))
                                || (y.re == '0 && y.im == '0))
            else $error("butterfly with equal inputs did not cancel");
    end

endmodule

// File: rtl/twiddle_rot.sv
module twiddle_rot
    import fft64_pkg::*;
(
    input  cplx_t            a,
    input  logic [LOG_N-1:0] m,
    output cplx_t            y
);
    cplx_t                w;
    logic signed [PW-1:0] pr;
    logic signed [PW-1:0] pi;
    logic signed [PW-1:0] rnd;

    always_comb begin
        w   = twiddle(m);
        rnd = PW'(1) <<< (FRAC - 1);
        pr  = PW'($signed(a.re)) * PW'($signed(w.re)) - PW'($signed(a.im)) * PW'($signed(w.im));
        pi  = PW'($signed(a.re)) * PW'($signed(w.im)) + PW'($signed(a.im)) * PW'($signed(w.re));
        y.re = clamp_dw((pr + rnd) >>> FRAC);
        y.im = clamp_dw((pi + rnd) >>> FRAC);
    end

    // R8
    always_comb begin
        unit_rot_chk: assert (!((m == '0) &&
                                ($signed(a.re) < 16384) && ($signed(a.re) > -16384) &&
                                ($signed(a.im) < 16384) && ($signed(a.im) > -16384))
                              || (y == a))
            else $error("zero-angle rotation changed its input");
    end

endmodule

// File: rtl/fft64_bin_select.sv
module fft64_bin_select
    import fft64_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NPT*DW-1:0]   smp_re,
    input  logic [NPT*DW-1:0]   smp_im,
    input  logic                bin_req,
    input  logic [LOG_N-1:0]    bin_idx,
    output logic                out_valid,
    output logic [DW-1:0]       bin_re,
    output logic [DW-1:0]       bin_im
);
    localparam int NB3 = RDX;

    cplx_t xin [NPT];

    cplx_t l1_d [NBF1];
    cplx_t l1_q [NBF1];
    cplx_t r1_d [NBF1];
    cplx_t r1_q [NBF1];
    cplx_t l2_d [NB3];
    cplx_t r2_d [NB3];
    cplx_t r2_q [NB3];
    cplx_t l3_d;

    logic [LOG_N-1:0] idx1;
    logic [LOG_N-1:0] idx2;
    logic [1:0]       idx3;
    logic             v1, v2, v3;

    for (genvar n = 0; n < NPT; n++) begin : g_unpack
        assign xin[n].re = smp_re[n*DW +: DW];
        assign xin[n].im = smp_im[n*DW +: DW];
    end

    // level 1: sixteen butterflies over n2, steered by k0
    for (genvar g = 0; g < NBF1; g++) begin : g_lvl1
        cplx_t grp [RDX];
        for (genvar j = 0; j < RDX; j++) begin : g_in
            assign grp[j] = xin[g + NBF1*j];
        end
        r4_pick_bfly i_bf (.a(grp), .k(bin_idx[1:0]), .y(l1_d[g]));
    end

    // rotation W64^(4*n1*k0)
    for (genvar g = 0; g < NBF1; g++) begin : g_rot1
        logic [LOG_N-1:0] ang;
        assign ang = {4'(2'(g / RDX) * idx1[1:0]), 2'b00};
        twiddle_rot i_rot (.a(l1_q[g]), .m(ang), .y(r1_d[g]));
    end

    // level 2: four butterflies over n1 steered by k1, then W64^(n0*(k0+4*k1))
    for (genvar n0 = 0; n0 < NB3; n0++) begin : g_lvl2
        cplx_t            grp [RDX];
        logic [LOG_N-1:0] ang;
        for (genvar j = 0; j < RDX; j++) begin : g_in
            assign grp[j] = r1_q[n0 + RDX*j];
        end
        r4_pick_bfly i_bf (.a(grp), .k(idx2[3:2]), .y(l2_d[n0]));
        assign ang = LOG_N'(2'(n0) * idx2[3:0]);
        twiddle_rot i_rot (.a(l2_d[n0]), .m(ang), .y(r2_d[n0]));
    end

    // level 3: one butterfly over n0 steered by k2
    r4_pick_bfly i_bf3 (.a(r2_q), .k(idx3), .y(l3_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            v3        <= 1'b0;
            out_valid <= 1'b0;
            bin_re    <= '0;
            bin_im    <= '0;
        end else begin
            v1        <= bin_req;
            v2        <= v1;
            v3        <= v2;
            out_valid <= v3;
            if (v3) begin
                bin_re <= l3_d.re;
                bin_im <= l3_d.im;
            end
        end
    end

    always_ff @(posedge clk) begin
        idx1 <= bin_idx;
        idx2 <= idx1;
        idx3 <= idx2[5:4];
        l1_q <= l1_d;
        r1_q <= r1_d;
        r2_q <= r2_d;
    end

    // checker state: cycles since reset, saturating
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                     since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 3'(LAT)) |-> !out_valid);

    // R2
    lat_match_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'(LAT)) |-> (out_valid == $past(bin_req, 4)));

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 3'd1) && !out_valid) |-> ($stable(bin_re) && $stable(bin_im)));

endmodule

// File: tb/test_fft64_bin_select.sv
module test_fft64_bin_select;
    import fft64_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic [NPT*DW-1:0]   smp_re;
    logic [NPT*DW-1:0]   smp_im;
    logic                bin_req;
    logic [LOG_N-1:0]    bin_idx;
    logic                out_valid;
    logic [DW-1:0]       bin_re;
    logic [DW-1:0]       bin_im;

    always #10 clk = ~clk;

    fft64_bin_select i_fft64_bin_select (
        .clk(clk), .rst(rst), .smp_re(smp_re), .smp_im(smp_im),
        .bin_req(bin_req), .bin_idx(bin_idx),
        .out_valid(out_valid), .bin_re(bin_re), .bin_im(bin_im)
    );

    int    total = 0;
    int    bad   = 0;
    int    xr [NPT];
    int    xi [NPT];
    int    er [NPT];
    int    ei [NPT];
    int    tol;
    string req_tag;
    bit    hv [LAT];
    int    hs [LAT];
    int    last_re, last_im;

    task automatic report(input string req, input string what, input int act, input int exp);
        bad++;
        $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    endtask

    function automatic int rnd_int(input real r);
        return $rtoi($floor(r + 0.5));
    endfunction

    task automatic build_ref();
        for (int k = 0; k < NPT; k++) begin
            real sr, si, ang;
            sr = 0.0; si = 0.0;
            for (int n = 0; n < NPT; n++) begin
                ang = 2.0 * 3.14159265358979 * real'((n * k) % NPT) / real'(NPT);
                sr += real'(xr[n]) * $cos(ang) + real'(xi[n]) * $sin(ang);
                si += real'(xi[n]) * $cos(ang) - real'(xr[n]) * $sin(ang);
            end
            er[k] = rnd_int(sr / real'(NPT));
            ei[k] = rnd_int(si / real'(NPT));
        end
        for (int n = 0; n < NPT; n++) begin
            smp_re[n*DW +: DW] = DW'(xr[n]);
            smp_im[n*DW +: DW] = DW'(xi[n]);
        end
    endtask

    // one cycle: check what arrives now, then drive the next request
    task automatic step(input bit v, input int k);
        int ar, ai, d;
        @(negedge clk);
        total++;
        if (out_valid !== hv[LAT-1])
            report("R2", "out_valid timing", int'(out_valid), int'(hv[LAT-1]));
        ar = int'($signed(bin_re));
        ai = int'($signed(bin_im));
        if (hv[LAT-1]) begin
            // R3: result must belong to the index requested four clocks earlier
            total++;
            d = ar - er[hs[LAT-1]];
            if (d > tol || d < -tol)
                report(req_tag, $sformatf("re bin %0d (R3 order)", hs[LAT-1]), ar, er[hs[LAT-1]]);
            total++;
            d = ai - ei[hs[LAT-1]];
            if (d > tol || d < -tol)
                report(req_tag, $sformatf("im bin %0d (R3 order)", hs[LAT-1]), ai, ei[hs[LAT-1]]);
            last_re = ar;
            last_im = ai;
        end else begin
            total++;
            if (ar != last_re || ai != last_im)
                report("R7", "held output re", ar, last_re);
        end
        for (int i = LAT - 1; i > 0; i--) begin
            hv[i] = hv[i-1];
            hs[i] = hs[i-1];
        end
        hv[0]   = v;
        hs[0]   = k;
        bin_req = v;
        bin_idx = LOG_N'(k);
    endtask

    task automatic drain();
        for (int i = 0; i < LAT + 1; i++) step(1'b0, 0);
    endtask

    task automatic sweep();
        for (int k = 0; k < NPT; k++) step(1'b1, k);
        drain();
    endtask

    task automatic random_run(input int cycles);
        for (int c = 0; c < cycles; c++)
            step(($urandom % 4) != 0, int'($urandom % NPT));
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4171));
        rst     = 1'b1;
        bin_req = 1'b1;
        bin_idx = '0;
        smp_re  = '0;
        smp_im  = '0;
        for (int i = 0; i < LAT; i++) begin hv[i] = 1'b0; hs[i] = 0; end
        last_re = 0; last_im = 0;
        tol = 0; req_tag = "R5";

        // R1: requests during reset are dropped, outputs idle
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) report("R1", "out_valid in reset", int'(out_valid), 0);
        total++;
        if (bin_re !== '0 || bin_im !== '0) report("R1", "bin_re in reset", int'(bin_re), 0);
        bin_req = 1'b0;
        rst     = 1'b0;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) report("R1", "out_valid after release", int'(out_valid), 0);
        drain();

        // R5: constant input, back-to-back sweep (R3)
        for (int n = 0; n < NPT; n++) begin xr[n] = 1234; xi[n] = -500; end
        build_ref();
        tol = 0; req_tag = "R5";
        sweep();

        // R6: impulse at sample 0
        for (int n = 0; n < NPT; n++) begin xr[n] = 0; xi[n] = 0; end
        xr[0] = 6400;
        build_ref();
        tol = 0; req_tag = "R6";
        sweep();

        // R4: random sample sets
        for (int s = 0; s < 5; s++) begin
            for (int n = 0; n < NPT; n++) begin
                xr[n] = int'($urandom_range(16382)) - 8191;
                xi[n] = int'($urandom_range(16382)) - 8191;
            end
            build_ref();
            tol = 2; req_tag = "R4";
            if (s == 0) sweep();
            random_run(150);
        end

        // R4: cosine tone at bin 5, descending sweep
        for (int n = 0; n < NPT; n++) begin
            xr[n] = rnd_int(8000.0 * $cos(2.0 * 3.14159265358979 * real'(5 * n) / 64.0));
            xi[n] = 0;
        end
        build_ref();
        tol = 2; req_tag = "R4";
        for (int k = NPT - 1; k >= 0; k--) step(1'b1, k);
        drain();

        // R1: reset while the pipeline is full
        for (int k = 0; k < 3; k++) step(1'b1, k);
        @(negedge clk);
        rst     = 1'b1;
        bin_req = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) report("R1", "out_valid after mid reset", int'(out_valid), 0);
        total++;
        if (bin_re !== '0) report("R1", "bin_re after mid reset", int'(bin_re), 0);
        rst     = 1'b0;
        bin_req = 1'b0;
        for (int i = 0; i < LAT; i++) begin hv[i] = 1'b0; hs[i] = 0; end
        last_re = 0; last_im = 0;
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule